// File: doc/BRIEF.md
# Addressed Serial Control Register Receiver

This block takes 8-bit words from a three-wire serial bus (data, bit clock, enable) and turns them into the settings a frequency synthesizer runs on: operating-mode control bits and the two divider values, a programmable-counter value (PC) and a swallow-counter value (SC). The three serial lines are asynchronous to the system clock. They pass through synchronizers, and bits are taken on rising edges of the serial clock while enable is high. A transfer ends when enable falls. Only then is the word checked, and only a valid word is committed.

The top two bits of each word select one of four destinations. The controller may send the words in any order and may repeat any of them. The divider value is double-buffered: the two PC words only load a shadow copy. The shadow PC goes to the active PC output in the same cycle that an SC word commits, so the dividers never see a PC that does not match its SC.

Top module: `scr_top`

## Requirements
- R1: Bits are captured on rising serial-clock edges while enable is high, most significant bit first. The first bit becomes word bit 7 and the eighth bit becomes word bit 0.
- R2: Word bits 7:6 select the destination: 00 is control, 01 is PC bits 7:2 (carried in word bits 5:0), 10 is PC bits 1:0 (carried in word bits 5:4), and 11 is SC bits 5:0 (carried in word bits 5:0).
- R3: A valid control word sets its fields at the end of the transfer. Bit 5 is run (0 drives `standby_o` high), bit 4 selects the FM band, bit 3 selects the higher reference step, and bits 2:1 set the pump current code.
- R4: If enable falls after any number of serial-clock rising edges other than exactly 8, the word is discarded and no output changes.
- R5: A word whose reserved bits are not zero is discarded and no output changes. The reserved bits are bit 0 of a control word and bits 3:0 of a PC-low word.
- R6: PC words only update a shadow value. `pc_o` keeps its old value until an SC word commits.
- R7: A valid SC word updates `sc_o` with its bits 5:0. In the same cycle, `pc_o` takes the shadow PC.
- R8: Words may arrive in any order and any number of times. A later PC word overwrites the shadow. An SC word with no new PC words reapplies the current shadow.
- R9: After reset, every register is zero: `pc_o`, `sc_o`, `band_fm_o`, `step_hi_o` and `pump_cur_o` read 0 and `standby_o` reads 1.
- R10: Serial-clock edges while enable is low shift nothing and do not count toward the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_en_i | input | 1 | Transfer enable, high while a word is sent |
| standby_o | output | 1 | High while run is clear |
| band_fm_o | output | 1 | FM band selected |
| step_hi_o | output | 1 | Higher reference step selected |
| pump_cur_o | output | 2 | Charge-pump current code |
| pc_o | output | 8 | Active programmable-counter value |
| sc_o | output | 6 | Active swallow-counter value |

## Verification
The bench targets transfers with 7 or 9 bits. A design that commits on a wrong count would latch a word shifted by one bit and corrupt an output. It sets reserved bits to catch a design that ignores the format check and loads garbage. It sends PC words with no SC word behind them: a design without the shadow would move `pc_o` early. It also toggles the serial clock while enable is low; a receiver that counts those edges would reject the next valid word. Random word streams in any order and with repeats then compare the double-buffered PC against a model of the shadow.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int WORD_W = 8;
    localparam int ADDR_W = 2;
    localparam int DATA_W = WORD_W - ADDR_W;
    localparam int PC_W   = 8;
    localparam int SC_W   = 6;
    localparam int PCL_W  = PC_W - DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'b00,
        ADR_PCH  = 2'b01,
        ADR_PCL  = 2'b10,
        ADR_SC   = 2'b11
    } word_addr_e;

    typedef struct packed {
        logic       run;
        logic       band_fm;
        logic       step_hi;
        logic [1:0] pump;
    } ctrl_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/scr_shift.sv
module scr_shift
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              sen_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic              sen_prev;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              commit;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      bit_edge, xfer_end;

    always_comb begin
        bit_edge     = sclk_i & ~st_q.sclk_prev;
        xfer_end     = st_q.sen_prev & ~sen_i;
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.sen_prev  = sen_i;
        st_d.commit    = 1'b0;
        if (sen_i && bit_edge) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdat_i};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (xfer_end) begin
            if (st_q.cnt == CNT_FULL) begin
                st_d.word   = st_q.shreg;
                st_d.commit = 1'b1;
            end
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = st_q.commit;
    assign word_o   = st_q.word;

    // R4: a commit follows only a transfer of exactly one full word
    a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |-> $past(st_q.cnt == CNT_FULL));

    // R1: the bit counter never runs past its saturation value
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);

    // R10: while enable is low the counter stays at zero
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_i |=> st_q.cnt == '0);
endmodule

// File: rtl/scr_regs.sv
module scr_regs
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output ctrl_t             ctrl_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [SC_W-1:0]   sc_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] pch_sh;
        logic [PCL_W-1:0]  pcl_sh;
        logic [PC_W-1:0]   pc_act;
        logic [SC_W-1:0]   sc_act;
    } regs_st_t;

    regs_st_t   st_d, st_q;
    word_addr_e addr;
    logic [DATA_W-1:0] payload;
    logic       fmt_ok;
    logic [3:0] sel;

    always_comb begin
        addr    = word_addr_e'(word_i[WORD_W-1:DATA_W]);
        payload = word_i[DATA_W-1:0];
        unique case (addr)
            ADR_CTRL: fmt_ok = (payload[0] == 1'b0);
            ADR_PCL:  fmt_ok = (payload[DATA_W-PCL_W-1:0] == '0);
            default:  fmt_ok = 1'b1;
        endcase
        sel = '0;
        if (commit_i && fmt_ok) sel[addr] = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (sel[ADR_CTRL]) begin
            st_d.ctrl.run     = payload[5];
            st_d.ctrl.band_fm = payload[4];
            st_d.ctrl.step_hi = payload[3];
            st_d.ctrl.pump    = payload[2:1];
        end
        if (sel[ADR_PCH]) st_d.pch_sh = payload;
        if (sel[ADR_PCL]) st_d.pcl_sh = payload[DATA_W-1:DATA_W-PCL_W];
        if (sel[ADR_SC]) begin
            st_d.sc_act = payload[SC_W-1:0];
            st_d.pc_act = {st_q.pch_sh, st_q.pcl_sh};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign pc_o   = st_q.pc_act;
    assign sc_o   = st_q.sc_act;

    // R2: at most one destination is written per commit
    a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R6: the active PC moves only after an SC commit
    a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pc_act != $past(st_q.pc_act)) |-> $past(commit_i && word_i[7:6] == 2'b11));

    // R7: the active SC moves only after an SC commit
    a_r7_sc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sc_act != $past(st_q.sc_act)) |-> $past(commit_i && word_i[7:6] == 2'b11));

    // R3: control fields move only after a well-formed control commit
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl != $past(st_q.ctrl)) |->
            $past(commit_i && word_i[7:6] == 2'b00 && !word_i[0]));

    // R5: a PC-low word with reserved bits set leaves the shadow alone
    a_r5_reserved_pcl: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && word_i[7:6] == 2'b10 && word_i[3:0] != 4'h0) |=> $stable(st_q.pcl_sh));
endmodule

// File: rtl/scr_top.sv
module scr_top
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk_i,
    input  logic            ser_dat_i,
    input  logic            ser_en_i,
    output logic            standby_o,
    output logic            band_fm_o,
    output logic            step_hi_o,
    output logic [1:0]      pump_cur_o,
    output logic [PC_W-1:0] pc_o,
    output logic [SC_W-1:0] sc_o
);
    localparam int LINES = 3;

    logic [LINES-1:0]  raw_lines, sync_lines;
    logic              commit;
    logic [WORD_W-1:0] word;
    ctrl_t             ctrl;

    assign raw_lines = {ser_en_i, ser_dat_i, ser_clk_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    scr_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sync_lines[0]),
        .sdat_i  (sync_lines[1]),
        .sen_i   (sync_lines[2]),
        .commit_o(commit),
        .word_o  (word)
    );

    scr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .word_i  (word),
        .ctrl_o  (ctrl),
        .pc_o    (pc_o),
        .sc_o    (sc_o)
    );

    assign standby_o  = ~ctrl.run;
    assign band_fm_o  = ctrl.band_fm;
    assign step_hi_o  = ctrl.step_hi;
    assign pump_cur_o = ctrl.pump;
endmodule

// File: tb/scr_top_bench.sv
module scr_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic       standby, band_fm, step_hi;
    logic [1:0] pump;
    logic [7:0] pc;
    logic [5:0] sc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected state
    bit       m_run, m_fm, m_step;
    bit [1:0] m_pump;
    bit [5:0] m_pch;
    bit [1:0] m_pcl;
    bit [7:0] m_pc;
    bit [5:0] m_sc;

    localparam int HOLD = 3;

    always #10 clk = ~clk;

    scr_top u_scr_top (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_en_i(ser_en),
        .standby_o(standby), .band_fm_o(band_fm), .step_hi_o(step_hi),
        .pump_cur_o(pump), .pc_o(pc), .sc_o(sc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "standby", int'(standby), int'(!m_run));
        chk(req, "band_fm", int'(band_fm), int'(m_fm));
        chk(req, "step_hi", int'(step_hi), int'(m_step));
        chk(req, "pump", int'(pump), int'(m_pump));
        chk(req, "pc", int'(pc), int'(m_pc));
        chk(req, "sc", int'(sc), int'(m_sc));
    endtask

    function automatic bit [7:0] mk(input bit [1:0] a, input bit [5:0] d);
        return {a, d};
    endfunction

    task automatic model_apply(input bit [7:0] w, input int n);
        if (n != 8) return;
        case (w[7:6])
            2'b00: if (!w[0]) begin
                m_run = w[5]; m_fm = w[4]; m_step = w[3]; m_pump = w[2:1];
            end
            2'b01: m_pch = w[5:0];
            2'b10: if (w[3:0] == 4'h0) m_pcl = w[5:4];
            default: begin m_pc = {m_pch, m_pcl}; m_sc = w[5:0]; end
        endcase
    endtask

    task automatic send(input bit [7:0] w, input int n);
        @(negedge clk);
        ser_en = 1'b1;
        repeat (HOLD) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_dat = (i < 8) ? w[7-i] : 1'b0;
            ser_clk = 1'b0;
            repeat (HOLD) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HOLD) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (HOLD) @(negedge clk);
        ser_en = 1'b0;
        repeat (10) @(negedge clk);
        model_apply(w, n);
    endtask

    task automatic stray_clocks(input int k);
        ser_dat = 1'b1;
        for (int i = 0; i < k; i++) begin
            ser_clk = 1'b1; repeat (HOLD) @(negedge clk);
            ser_clk = 1'b0; repeat (HOLD) @(negedge clk);
        end
        ser_dat = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1357_9bdf);
        repeat (4) @(negedge clk);
        // R9: reset state
        chk_all("R9");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_all("R9");

        // R3: control fields
        send(mk(2'b00, 6'b101010), 8);
        chk_all("R3");
        send(mk(2'b00, 6'b011100), 8);
        chk_all("R3");

        // R6: PC words only load the shadow
        send(mk(2'b01, 6'b101101), 8);
        send(mk(2'b10, 6'b110000), 8);
        chk("R6", "pc held", int'(pc), 0);
        chk_all("R6");

        // R7 / R1 / R2: SC applies the shadow PC together with SC
        send(mk(2'b11, 6'b100111), 8);
        chk("R7", "pc applied", int'(pc), 8'hB7);
        chk("R1", "sc bit order", int'(sc), 6'h27);
        chk_all("R2");

        // R4: short and long transfers discarded
        send(mk(2'b11, 6'b000001), 7);
        chk_all("R4");
        send(mk(2'b00, 6'b100000), 9);
        chk_all("R4");

        // R5: reserved bits set
        send(mk(2'b00, 6'b000001), 8);
        chk_all("R5");
        send(mk(2'b10, 6'b010100), 8);
        send(mk(2'b11, 6'b000011), 8);
        chk("R5", "pcl kept", int'(pc[1:0]), 2'b11);
        chk_all("R5");

        // R10: clock edges with enable low ignored
        stray_clocks(3);
        send(mk(2'b11, 6'b111000), 8);
        chk("R10", "word after stray edges", int'(sc), 6'h38);
        chk_all("R10");

        // R8: random order and repeats
        for (int t = 0; t < 250; t++) begin
            bit [7:0] w;
            int n;
            w = 8'($urandom);
            n = 8;
            if (($urandom % 8) == 0) n = (($urandom % 2) == 0) ? 7 : 9;
            send(w, n);
            chk_all("R8");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule